// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block brings one gated power domain up or down on request. A requester pulses `start` together with `pwr_on_req` (1 = power up, 0 = power down). The sequencer then steps through a fixed, ordered series of writes to the domain's control word: active-low reset, isolation, two staged power-switch enables and a clock-disable bit, plus the SRAM power-down field and a bus-protection request. Between some of these writes it waits on the domain's two power-status acknowledges or on the SRAM power-down acknowledges.

Every wait samples its condition at a fixed poll interval and gives up after a bounded number of polls. On success `done` pulses for one cycle. On a timeout `err` pulses, the control word is left exactly as it was when the wait expired, and the block returns to idle. Parameters select the SRAM field masks, whether the domain uses bus protection, the poll interval and poll budget in clock cycles, and an optional fixed wait that replaces SRAM acknowledge polling during power-up.

Top module: `pwr_domain_seq`

## Requirements
- R1: Out of reset the control word reads as a fully off domain: bit 0 (reset_n) = 0, bit 1 (isolate) = 1, bit 2 (primary switch) = 0, bit 3 (secondary switch) = 0, bit 4 (clock disable) = 1, every SRAM power-down bit in SRAM_PDN_MASK = 1. `bus_prot` = 1 when bus protection is enabled, and `busy` = 0.
- R2: A request is taken only while idle. `busy` is high from the cycle after the accepted `start` until the cycle `done` or `err` is raised, where it is low. A `start` seen while busy has no effect on the sequence.
- R3: Power-up sets the primary switch (bit 2) first and sets the secondary switch (bit 3) in a later cycle. It then waits for the status check.
- R4: The domain counts as on only when `sta_pri` and `sta_sec` are both 1. It counts as off only when both are 0. While exactly one is set, the sequencer keeps waiting and changes no control bit.
- R5: After the power-on acknowledge, the sequencer clears clock disable. It then clears isolation, then sets reset_n, then clears the SRAM power-down bits. Next it waits until every bit of `sram_ack_word` under SRAM_ACK_MASK reads 0. Bus protection is released last.
- R6: Power-down first asserts bus protection. It then sets the SRAM power-down bits and waits until every masked acknowledge bit reads 1. After that it sets isolation, clears reset_n, sets clock disable, clears the primary switch and clears the secondary switch. Finally it waits until both status bits read 0.
- R7: A wait samples its condition once on entry and then every POLL_CYCLES cycles. If the condition is still false at poll number TIMEOUT_POLLS, `err` pulses for one cycle, the control word and `bus_prot` stay frozen, and the block returns to idle, ready for a new request.
- R8: With FORCE_WAIT = 1, the power-up SRAM wait ignores `sram_ack_word`. `done` rises exactly FORCE_WAIT_CYCLES cycles after the SRAM power-down bits are seen cleared.
- R9: With BUS_PROT_EN = 0, both bus-protection steps are skipped and `bus_prot` stays 0. With SRAM_ACK_MASK = 0, an SRAM wait is met at its first poll. A narrow SRAM field (for example only bit 8) is driven on exactly its mask bits.
- R10: `done` and `err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| pwr_on_req | input | 1 | Direction of the request: 1 power up, 0 power down |
| sta_pri | input | 1 | Primary power-status acknowledge |
| sta_sec | input | 1 | Secondary power-status acknowledge |
| sram_ack_word | input | CW | Readback holding the SRAM power-down acknowledges |
| ctrl_word | output | CW | Domain control word: bits 4:0 control, SRAM field per mask |
| bus_prot | output | 1 | Bus-protection request toward the interconnect |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse when a wait timed out |

## Verification
The sequencer is driven against a modelled domain whose status and SRAM acknowledges follow the control word after a delay. This exposes the full order of control-word values for power-up and power-down, and any misordered or merged step shows up as a wrong list. A run that holds one status bit low for a while tells the "both set" rule apart from an "either set" rule. A run that holds it low for good separates timeout, freeze and recovery from normal completion. A second instance with a forced wait, no bus protection, an empty acknowledge mask and a one-bit SRAM field shows that the forced wait has the exact length set by its parameter, and that the skipped steps really vanish from the sequence.

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int            CW                = 16,
  parameter logic [CW-1:0] SRAM_PDN_MASK     = 16'h0F00,
  parameter logic [CW-1:0] SRAM_ACK_MASK     = 16'hF000,
  parameter bit            BUS_PROT_EN       = 1'b1,
  parameter int            POLL_CYCLES       = 1000,
  parameter int            TIMEOUT_POLLS     = 100000,
  parameter bit            FORCE_WAIT        = 1'b0,
  parameter int            FORCE_WAIT_CYCLES = 1200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pwr_on_req,
  input  logic          sta_pri,
  input  logic          sta_sec,
  input  logic [CW-1:0] sram_ack_word,
  output logic [CW-1:0] ctrl_word,
  output logic          bus_prot,
  output logic          busy,
  output logic          done,
  output logic          err
);

  localparam int PW  = $clog2(POLL_CYCLES + 1);
  localparam int NW  = $clog2(TIMEOUT_POLLS + 1);
  localparam int FWW = $clog2(FORCE_WAIT_CYCLES + 1);
  localparam logic [4:0] CTL_OFF = 5'b10010;

  typedef enum logic [4:0] {
    S_IDLE,
    S_UP_P1, S_UP_P2, S_UP_STA, S_UP_CLK, S_UP_ISO, S_UP_RST,
    S_UP_SRAM, S_UP_ACK, S_UP_BUS,
    S_DN_BUS, S_DN_SRAM, S_DN_ACK, S_DN_ISO, S_DN_RST, S_DN_CLK,
    S_DN_P1, S_DN_P2, S_DN_STA
  } state_t;

  state_t         state;
  logic [4:0]     ctl;
  logic           pdn;
  logic           bp;
  logic [PW-1:0]  tmr;
  logic [NW-1:0]  npoll;
  logic [FWW-1:0] fcnt;

  logic waiting, fwait, poll_now, cond, go, expire;
  logic sta_on, sta_off, ack_clr, ack_set;

  assign sta_on   = sta_pri & sta_sec;
  assign sta_off  = ~sta_pri & ~sta_sec;
  assign ack_clr  = (sram_ack_word & SRAM_ACK_MASK) == '0;
  assign ack_set  = (sram_ack_word & SRAM_ACK_MASK) == SRAM_ACK_MASK;

  assign waiting  = (state == S_UP_STA) || (state == S_UP_ACK) ||
                    (state == S_DN_ACK) || (state == S_DN_STA);
  assign fwait    = FORCE_WAIT && (state == S_UP_ACK);
  assign poll_now = (tmr == '0);

  always_comb begin
    case (state)
      S_UP_STA: cond = sta_on;
      S_UP_ACK: cond = ack_clr;
      S_DN_ACK: cond = ack_set;
      S_DN_STA: cond = sta_off;
      default:  cond = 1'b0;
    endcase
  end

  assign go     = fwait ? (fcnt == FWW'(FORCE_WAIT_CYCLES - 1)) : (poll_now && cond);
  assign expire = waiting && !fwait && poll_now && !cond &&
                  (npoll == NW'(TIMEOUT_POLLS - 1));

  assign ctrl_word = (pdn ? SRAM_PDN_MASK : '0) | {{(CW-5){1'b0}}, ctl};
  assign bus_prot  = BUS_PROT_EN & bp;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctl   <= CTL_OFF;
      pdn   <= 1'b1;
      bp    <= 1'b1;
      tmr   <= '0;
      npoll <= '0;
      fcnt  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!waiting) begin
        tmr   <= '0;
        npoll <= '0;
        fcnt  <= '0;
      end
      case (state)
        S_IDLE:    if (start) state <= pwr_on_req ? S_UP_P1 :
                                       (BUS_PROT_EN ? S_DN_BUS : S_DN_SRAM);
        S_UP_P1:   begin ctl[2] <= 1'b1; state <= S_UP_P2;   end
        S_UP_P2:   begin ctl[3] <= 1'b1; state <= S_UP_STA;  end
        S_UP_STA:  if (go) state <= S_UP_CLK;
        S_UP_CLK:  begin ctl[4] <= 1'b0; state <= S_UP_ISO;  end
        S_UP_ISO:  begin ctl[1] <= 1'b0; state <= S_UP_RST;  end
        S_UP_RST:  begin ctl[0] <= 1'b1; state <= S_UP_SRAM; end
        S_UP_SRAM: begin pdn    <= 1'b0; state <= S_UP_ACK;  end
        S_UP_ACK:  if (go) begin
                     if (BUS_PROT_EN) state <= S_UP_BUS;
                     else begin done <= 1'b1; state <= S_IDLE; end
                   end
        S_UP_BUS:  begin bp <= 1'b0; done <= 1'b1; state <= S_IDLE; end
        S_DN_BUS:  begin bp     <= 1'b1; state <= S_DN_SRAM; end
        S_DN_SRAM: begin pdn    <= 1'b1; state <= S_DN_ACK;  end
        S_DN_ACK:  if (go) state <= S_DN_ISO;
        S_DN_ISO:  begin ctl[1] <= 1'b1; state <= S_DN_RST;  end
        S_DN_RST:  begin ctl[0] <= 1'b0; state <= S_DN_CLK;  end
        S_DN_CLK:  begin ctl[4] <= 1'b1; state <= S_DN_P1;   end
        S_DN_P1:   begin ctl[2] <= 1'b0; state <= S_DN_P2;   end
        S_DN_P2:   begin ctl[3] <= 1'b0; state <= S_DN_STA;  end
        S_DN_STA:  if (go) begin done <= 1'b1; state <= S_IDLE; end
        default:   state <= S_IDLE;
      endcase
      if (waiting && !go) begin
        if (expire) begin
          err   <= 1'b1;
          state <= S_IDLE;
        end else if (fwait) begin
          fcnt <= fcnt + 1'b1;
        end else if (poll_now) begin
          npoll <= npoll + 1'b1;
          tmr   <= PW'(POLL_CYCLES - 1);
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

  a_r3_sec_after_pri: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[3]) |-> ctl[2]);

  a_r4_clk_on_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[4]) |-> $past(sta_pri && sta_sec, 2));

  a_r5_rst_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[0]) |-> !ctl[1]);

  a_r5_bus_release_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bp) |-> (!pdn && ctl[0] && !ctl[1] && !ctl[4]));

  a_r6_switch_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl[2]) |-> (ctl[1] && !ctl[0] && ctl[4] && pdn));

  a_r7_freeze_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(ctl) && $stable(pdn) && $stable(bp)));

  a_r2_idle_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

endmodule

// File: tb/sim_pwr_domain_seq.sv
module sim_pwr_domain_seq;
  localparam int CLK_P = 10;
  localparam int FWC   = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic start0 = 1'b0, on0 = 1'b0, start1 = 1'b0, on1 = 1'b0;
  logic stuck2 = 1'b0;
  logic [15:0] ctrl0, ctrl1, ack0, ack1;
  logic bus0, busy0, done0, err0, bus1, busy1, done1, err1;
  logic sta_p0, sta_s0, sta_p1, sta_s1;
  logic [3:0] d_p0 = '0, d_s0 = '0, d_m0 = 4'hF, d_p1 = '0, d_s1 = '0;

  always @(posedge clk) begin
    d_p0 <= {d_p0[2:0], ctrl0[2]};
    d_s0 <= {d_s0[2:0], ctrl0[3]};
    d_m0 <= {d_m0[2:0], ctrl0[8]};
    d_p1 <= {d_p1[2:0], ctrl1[2]};
    d_s1 <= {d_s1[2:0], ctrl1[3]};
  end
  assign sta_p0 = d_p0[3];
  assign sta_s0 = d_s0[3] & ~stuck2;
  assign ack0   = {{4{d_m0[3]}}, 12'h000};
  assign sta_p1 = d_p1[3];
  assign sta_s1 = d_s1[3];
  assign ack1   = 16'hFFFF;

  pwr_domain_seq #(.POLL_CYCLES(4), .TIMEOUT_POLLS(20)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .pwr_on_req(on0),
    .sta_pri(sta_p0), .sta_sec(sta_s0), .sram_ack_word(ack0),
    .ctrl_word(ctrl0), .bus_prot(bus0), .busy(busy0), .done(done0), .err(err0));

  pwr_domain_seq #(.SRAM_PDN_MASK(16'h0100), .SRAM_ACK_MASK(16'h0000),
                   .BUS_PROT_EN(1'b0), .POLL_CYCLES(4), .TIMEOUT_POLLS(20),
                   .FORCE_WAIT(1'b1), .FORCE_WAIT_CYCLES(FWC)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .pwr_on_req(on1),
    .sta_pri(sta_p1), .sta_sec(sta_s1), .sram_ack_word(ack1),
    .ctrl_word(ctrl1), .bus_prot(bus1), .busy(busy1), .done(done1), .err(err1));

  int n_chk = 0, n_bad = 0;
  logic [9:0] lg [0:31];
  int lg_n;
  bit saw_done, saw_err, post_pulse, poke_busy, mid_busy, bus1_hi;
  int t_end, t_sram;
  logic [15:0] mid_ctrl;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pk(input logic [4:0] c, input logic [3:0] s, input logic b);
    return {c, s, b};
  endfunction

  function automatic logic [9:0] snap(input bit which);
    return which ? {ctrl1[4:0], ctrl1[11:8], bus1} : {ctrl0[4:0], ctrl0[11:8], bus0};
  endfunction

  task automatic run(input bit which, input bit on, input int stuck_at, input bit poke);
    logic [9:0] s;
    lg_n = 0; saw_done = 0; saw_err = 0; t_end = -1; t_sram = -1;
    poke_busy = 0; mid_busy = 0; mid_ctrl = '0; bus1_hi = 0;
    lg[0] = snap(which); lg_n = 1;
    if (which) begin start1 = 1; on1 = on; end else begin start0 = 1; on0 = on; end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 0) begin start0 = 0; start1 = 0; end
      if (poke && i == 2) begin
        poke_busy = which ? busy1 : busy0;
        if (which) begin start1 = 1; on1 = ~on; end else begin start0 = 1; on0 = ~on; end
      end
      if (poke && i == 3) begin start0 = 0; start1 = 0; end
      if (stuck_at > 0 && i == stuck_at - 1) begin
        mid_ctrl = ctrl0; mid_busy = busy0;
      end
      if (stuck_at > 0 && i == stuck_at) stuck2 = 0;
      if (bus1) bus1_hi = 1;
      s = snap(which);
      if (s != lg[lg_n-1] && lg_n < 32) begin lg[lg_n] = s; lg_n++; end
      if (t_sram < 0 && s[4:1] == 4'h0) t_sram = i;
      if (which ? done1 : done0) begin saw_done = 1; t_end = i; break; end
      if (which ? err1 : err0) begin saw_err = 1; t_end = i; break; end
    end
    @(negedge clk);
    post_pulse = which ? (done1 | err1) : (done0 | err0);
  endtask

  task automatic cmp_seq(input logic [9:0] e [0:7], input int n, input string req);
    chk(lg_n == n, req, lg_n, n);
    for (int k = 0; k < n && k < lg_n; k++) chk(lg[k] == e[k], req, lg[k], e[k]);
  endtask

  task automatic t_reset();
    chk(ctrl0 == 16'h0F12, "R1", ctrl0, 16'h0F12);
    chk(bus0 == 1'b1, "R1", bus0, 1);
    chk(busy0 == 1'b0, "R1", busy0, 0);
    chk(ctrl1 == 16'h0112, "R9", ctrl1, 16'h0112);
    chk(bus1 == 1'b0, "R9", bus1, 0);
  endtask

  task automatic t_power_up();
    run(0, 1, 0, 1);
    chk(poke_busy == 1'b1, "R2", poke_busy, 1);
    cmp_seq('{pk(5'h12,4'hF,1), pk(5'h16,4'hF,1), pk(5'h1E,4'hF,1), pk(5'h0E,4'hF,1),
              pk(5'h0C,4'hF,1), pk(5'h0D,4'hF,1), pk(5'h0D,4'h0,1), pk(5'h0D,4'h0,0)},
            8, "R3_R5");
    chk(saw_done, "R2", saw_done, 1);
    chk(post_pulse == 1'b0, "R10", post_pulse, 0);
    chk(busy0 == 1'b0 && ctrl0 == 16'h000D, "R2", ctrl0, 16'h000D);
  endtask

  task automatic t_power_down(input string req);
    run(0, 0, 0, 0);
    cmp_seq('{pk(5'h0D,4'h0,0), pk(5'h0D,4'h0,1), pk(5'h0D,4'hF,1), pk(5'h0F,4'hF,1),
              pk(5'h0E,4'hF,1), pk(5'h1E,4'hF,1), pk(5'h1A,4'hF,1), pk(5'h12,4'hF,1)},
            8, req);
    chk(saw_done && !saw_err, req, saw_done, 1);
  endtask

  task automatic t_one_status();
    stuck2 = 1;
    run(0, 1, 30, 0);
    chk(mid_ctrl == 16'h0F1E, "R4", mid_ctrl, 16'h0F1E);
    chk(mid_busy == 1'b1, "R4", mid_busy, 1);
    chk(saw_done && t_end > 30, "R4", t_end, 31);
    chk(lg_n == 8 && lg[7] == pk(5'h0D,4'h0,0), "R4", lg[lg_n-1], pk(5'h0D,4'h0,0));
  endtask

  task automatic t_timeout();
    stuck2 = 1;
    run(0, 1, 0, 0);
    chk(saw_err && !saw_done, "R7", saw_err, 1);
    chk(t_end >= 70 && t_end <= 100, "R7", t_end, 80);
    chk(ctrl0 == 16'h0F1E && bus0 == 1'b1, "R7", ctrl0, 16'h0F1E);
    chk(busy0 == 1'b0, "R7", busy0, 0);
    chk(post_pulse == 1'b0, "R10", post_pulse, 0);
    repeat (5) @(negedge clk);
    chk(ctrl0 == 16'h0F1E, "R7", ctrl0, 16'h0F1E);
    stuck2 = 0;
    run(0, 0, 0, 0);
    cmp_seq('{pk(5'h1E,4'hF,1), pk(5'h1A,4'hF,1), pk(5'h12,4'hF,1), 10'h0,
              10'h0, 10'h0, 10'h0, 10'h0}, 3, "R7");
    chk(saw_done, "R7", saw_done, 1);
  endtask

  task automatic t_forced_wait();
    run(1, 1, 0, 0);
    cmp_seq('{pk(5'h12,4'h1,0), pk(5'h16,4'h1,0), pk(5'h1E,4'h1,0), pk(5'h0E,4'h1,0),
              pk(5'h0C,4'h1,0), pk(5'h0D,4'h1,0), pk(5'h0D,4'h0,0), 10'h0}, 7, "R9");
    chk(saw_done && (t_end - t_sram) == FWC, "R8", t_end - t_sram, FWC);
    chk(!bus1_hi, "R9", bus1_hi, 0);
    chk(ctrl1 == 16'h000D, "R9", ctrl1, 16'h000D);
    run(1, 0, 0, 0);
    cmp_seq('{pk(5'h0D,4'h0,0), pk(5'h0D,4'h1,0), pk(5'h0F,4'h1,0), pk(5'h0E,4'h1,0),
              pk(5'h1E,4'h1,0), pk(5'h1A,4'h1,0), pk(5'h12,4'h1,0), 10'h0}, 7, "R9");
    chk(saw_done && !bus1_hi, "R9", bus1_hi, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_power_down("R6");
    t_one_status();
    t_power_down("R6");
    t_timeout();
    t_forced_wait();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule